// File: doc/BRIEF.md
# Validation Coprocessor with Stall and Interrupt Timers

This unit sits beside a processor core as an attached coprocessor used only for core validation. It answers two coprocessor numbers: a primary number (4) with the full feature set and a secondary number (5) with register moves and the timer operations. It holds sixteen 32-bit general registers. The core moves words between its own registers and these registers. Memory-transfer instructions stream one or two words through the same registers. Data-processing operations give the core a programmable stall, schedule delayed fast and normal interrupt requests, release those requests, and record a free-running cycle count.

The core presents an instruction in a first cycle with `cp_first`. It gives the coprocessor number, an instruction class code and the 32-bit instruction word. In that same cycle the unit answers combinationally: `cp_claim` accepts the instruction, and when `cp_claim` stays low the core takes its undefined-instruction trap. A stall is signalled through `cp_busy`. The core then repeats a poll cycle (`cp_poll`) until `cp_busy` drops. Word transfers follow as data beats marked by `cp_data`. The unit drives `cp_rdata` during each beat and raises `cp_last` on the final beat. The interrupt outputs are active low.

Top module: `cpval_engine`

## Requirements
- R1: `cp_claim` is high only in a cycle with `cp_first` high and `cp_num` equal to 4 or 5. The `cp_kind` codes are 0 data-processing, 1 move to coprocessor, 2 move from coprocessor, 3 load to coprocessor, 4 store from coprocessor. An unclaimed instruction changes no register and no output.
- R2: Moves (kind 1 and 2) are claimed on both numbers and address the register given by instruction bits [19:16]. Each move has exactly one data beat, and that beat has `cp_last` high. In a kind 1 beat, `cp_wdata` is written. In a kind 2 beat, the register value is shown on `cp_rdata`.
- R3: Loads and stores (kind 3 and 4) are claimed only on number 4 and address the register given by bits [15:12]. With bit 22 set they take two beats, and without it one beat. Every beat addresses the same register, and only the final beat has `cp_last` high. After a two-word load, the register holds the second word.
- R4: In a data-processing instruction, the operation is bits [23:20] and the count N is the content of the register given by bits [3:0]. Operation 0 on either number is a stall. `cp_busy` is high in the first cycle exactly when N is nonzero. In the k-th poll cycle after the first cycle, `cp_busy` is high while k is less than N, using a wrap-safe comparison.
- R5: Operation 1 on number 5 drives `cp_nfiq` low after max(N,1) rising clock edges, counting the edge that ends the issuing cycle. The line then stays low until it is released.
- R6: Operation 2 on number 5 does the same for `cp_nirq`. The two lines and their countdowns are independent of each other.
- R7: Operation 3 on number 5 returns `cp_nfiq` high and operation 4 returns `cp_nirq` high. Either one also cancels a countdown still pending on its line.
- R8: A 32-bit cycle counter starts at zero at reset, advances by one every clock and wraps modulo 2^32. Operation 5 on number 5 writes the counter value of the issuing cycle into the register given by bits [3:0].
- R9: These are rejected: operations 6 to 15, operations 1 to 5 on number 4, and loads or stores on number 5. A rejected instruction leaves the interrupt lines and the registers unchanged.
- R10: After reset, every register reads zero, both interrupt lines are high, and `cp_busy`, `cp_claim` and `cp_last` are low.
- R11: A new operation 1 or 2 issued while its line's countdown is pending restarts that countdown from the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cp_first | input | 1 | First cycle of an instruction offered to the coprocessor |
| cp_num | input | 4 | Coprocessor number of the offered instruction |
| cp_kind | input | 3 | Instruction class code (see R1) |
| cp_instr | input | 32 | Instruction word |
| cp_poll | input | 1 | Core repeats a stalled instruction |
| cp_data | input | 1 | Data beat of a claimed transfer |
| cp_wdata | input | 32 | Word written during a beat |
| cp_claim | output | 1 | Instruction accepted (first cycle only) |
| cp_busy | output | 1 | Stall response |
| cp_last | output | 1 | Current beat is the final one |
| cp_rdata | output | 32 | Word read during a beat |
| cp_nfiq | output | 1 | Fast interrupt request, active low |
| cp_nirq | output | 1 | Normal interrupt request, active low |

## Verification
A countdown loaded with the wrong value, or decremented on the wrong edge, moves the falling edge of an interrupt line by whole cycles. The bench therefore samples each line one edge before and one edge after the expected fall. A corrupt stall deadline changes how many poll cycles see `cp_busy` high, and this shows on the first poll whose answer differs. A register written at the wrong index or with the wrong word appears at the next move-from beat that reads it. A transfer beat counter that is off shows as `cp_last` on the wrong beat within the same instruction.

// File: rtl/cpv_pkg.sv
package cpv_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned NUM_W   = 4;
    localparam int unsigned KIND_W  = 3;
    localparam int unsigned OP_W    = 4;

    typedef enum logic [KIND_W-1:0] {
        K_CDP = 3'd0,
        K_MCR = 3'd1,
        K_MRC = 3'd2,
        K_LDC = 3'd3,
        K_STC = 3'd4
    } kind_e;

    typedef enum logic [3:0] {
        C_NONE,
        C_MOVE_WR,
        C_MOVE_RD,
        C_MEM_WR,
        C_MEM_RD,
        C_STALL,
        C_FIQ_ARM,
        C_IRQ_ARM,
        C_FIQ_REL,
        C_IRQ_REL,
        C_STAMP
    } cls_e;

endpackage

// File: rtl/cpv_decode.sv
module cpv_decode
    import cpv_pkg::*;
#(
    parameter logic [NUM_W-1:0] CP_A = 4'd4,
    parameter logic [NUM_W-1:0] CP_B = 4'd5
) (
    input  logic              first_i,
    input  logic [NUM_W-1:0]  num_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [OP_W-1:0]   op_i,
    output cls_e              cls_o,
    output logic              claim_o
);

    logic is_a;
    logic is_b;

    always_comb begin
        is_a  = (num_i == CP_A);
        is_b  = (num_i == CP_B);
        cls_o = C_NONE;
        if (first_i && (is_a || is_b)) begin
            case (kind_e'(kind_i))
                K_MCR: cls_o = C_MOVE_WR;
                K_MRC: cls_o = C_MOVE_RD;
                K_LDC: if (is_a) cls_o = C_MEM_WR;
                K_STC: if (is_a) cls_o = C_MEM_RD;
                K_CDP: begin
                    if (op_i == 4'd0) begin
                        cls_o = C_STALL;
                    end else if (is_b) begin
                        case (op_i)
                            4'd1:    cls_o = C_FIQ_ARM;
                            4'd2:    cls_o = C_IRQ_ARM;
                            4'd3:    cls_o = C_FIQ_REL;
                            4'd4:    cls_o = C_IRQ_REL;
                            4'd5:    cls_o = C_STAMP;
                            default: cls_o = C_NONE;
                        endcase
                    end
                end
                default: cls_o = C_NONE;
            endcase
        end
        claim_o = (cls_o != C_NONE);
    end

endmodule

// File: rtl/cpv_regfile.sv
module cpv_regfile #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned REG_CNT = 16,
    localparam int unsigned IDX_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_a_i,
    output logic [DATA_W-1:0] rdata_a_o,
    input  logic [IDX_W-1:0]  raddr_b_i,
    output logic [DATA_W-1:0] rdata_b_o
);

    logic [DATA_W-1:0] regs_d [REG_CNT];
    logic [DATA_W-1:0] regs_q [REG_CNT];

    always_comb begin
        for (int i = 0; i < REG_CNT; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we_i) begin
            regs_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_CNT; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < REG_CNT; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rdata_a_o = regs_q[raddr_a_i];
    assign rdata_b_o = regs_q[raddr_b_i];

endmodule

// File: rtl/cpv_line_timer.sv
module cpv_line_timer #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             rel_i,
    output logic             line_n_o
);

    typedef struct packed {
        logic             low;
        logic             pend;
        logic [CNT_W-1:0] rem;
    } tmr_t;

    tmr_t t_d;
    tmr_t t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.pend) begin
            if (t_q.rem == CNT_W'(1)) begin
                t_d.low  = 1'b1;
                t_d.pend = 1'b0;
            end else begin
                t_d.rem = t_q.rem - CNT_W'(1);
            end
        end
        if (arm_i) begin
            if (count_i <= CNT_W'(1)) begin
                t_d.low  = 1'b1;
                t_d.pend = 1'b0;
            end else begin
                t_d.pend = 1'b1;
                t_d.rem  = count_i - CNT_W'(1);
            end
        end
        if (rel_i) begin
            t_d.low  = 1'b0;
            t_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign line_n_o = ~t_q.low;

endmodule

// File: rtl/cpval_engine.sv
module cpval_engine
    import cpv_pkg::*;
#(
    parameter int unsigned       DATA_W  = 32,
    parameter int unsigned       REG_CNT = 16,
    parameter logic [NUM_W-1:0]  CP_A    = 4'd4,
    parameter logic [NUM_W-1:0]  CP_B    = 4'd5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cp_first,
    input  logic [NUM_W-1:0]    cp_num,
    input  logic [KIND_W-1:0]   cp_kind,
    input  logic [INSTR_W-1:0]  cp_instr,
    input  logic                cp_poll,
    input  logic                cp_data,
    input  logic [DATA_W-1:0]   cp_wdata,
    output logic                cp_claim,
    output logic                cp_busy,
    output logic                cp_last,
    output logic [DATA_W-1:0]   cp_rdata,
    output logic                cp_nfiq,
    output logic                cp_nirq
);

    localparam int unsigned IDX_W    = $clog2(REG_CNT);
    localparam int unsigned LINES    = 2;
    localparam int unsigned MOVE_LSB = 16;
    localparam int unsigned MEM_LSB  = 12;
    localparam int unsigned OP_LSB   = 20;
    localparam int unsigned LONG_BIT = 22;

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              wait_on;
        logic [DATA_W-1:0] finish;
        logic              x_on;
        logic              x_wr;
        logic [IDX_W-1:0]  x_idx;
        logic [1:0]        x_beats;
    } eng_t;

    eng_t st_d;
    eng_t st_q;

    cls_e              cls;
    logic              claim;
    logic [IDX_W-1:0]  idx_move;
    logic [IDX_W-1:0]  idx_mem;
    logic [IDX_W-1:0]  idx_cnt;
    logic [DATA_W-1:0] span;
    logic [DATA_W-1:0] xfer_word;
    logic [DATA_W-1:0] gap;
    logic              beat;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_waddr;
    logic [DATA_W-1:0] rf_wdata;
    logic [LINES-1:0]  arm;
    logic [LINES-1:0]  rel;
    logic [LINES-1:0]  line_n;
    logic [DATA_W-1:0] cycle_q;

    assign idx_move = cp_instr[MOVE_LSB +: IDX_W];
    assign idx_mem  = cp_instr[MEM_LSB +: IDX_W];
    assign idx_cnt  = cp_instr[0 +: IDX_W];

    cpv_decode #(
        .CP_A (CP_A),
        .CP_B (CP_B)
    ) u_dec (
        .first_i (cp_first),
        .num_i   (cp_num),
        .kind_i  (cp_kind),
        .op_i    (cp_instr[OP_LSB +: OP_W]),
        .cls_o   (cls),
        .claim_o (claim)
    );

    cpv_regfile #(
        .DATA_W  (DATA_W),
        .REG_CNT (REG_CNT)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (rf_we),
        .waddr_i   (rf_waddr),
        .wdata_i   (rf_wdata),
        .raddr_a_i (idx_cnt),
        .rdata_a_o (span),
        .raddr_b_i (st_q.x_idx),
        .rdata_b_o (xfer_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + DATA_W'(1);
        cp_busy  = 1'b0;
        gap      = st_q.cnt - st_q.finish;

        // data beats of a transfer already claimed
        beat    = cp_data && st_q.x_on;
        cp_last = beat && (st_q.x_beats == 2'd1);
        if (beat) begin
            st_d.x_beats = st_q.x_beats - 2'd1;
            if (cp_last) begin
                st_d.x_on = 1'b0;
            end
        end

        // stall: first cycle, then repeated polls
        if (cls == C_STALL) begin
            cp_busy      = (span != '0);
            st_d.wait_on = (span != '0);
            st_d.finish  = st_q.cnt + span;
        end else if (cp_poll && st_q.wait_on) begin
            cp_busy = gap[DATA_W-1];
            if (!gap[DATA_W-1]) begin
                st_d.wait_on = 1'b0;
            end
        end

        // open a new transfer
        if (cls inside {C_MOVE_WR, C_MOVE_RD, C_MEM_WR, C_MEM_RD}) begin
            st_d.x_on    = 1'b1;
            st_d.x_wr    = (cls == C_MOVE_WR) || (cls == C_MEM_WR);
            st_d.x_idx   = (cls inside {C_MOVE_WR, C_MOVE_RD}) ? idx_move : idx_mem;
            st_d.x_beats = ((cls inside {C_MEM_WR, C_MEM_RD}) && cp_instr[LONG_BIT]) ? 2'd2 : 2'd1;
        end

        // single register write port: data beat wins over a stamp
        if (beat && st_q.x_wr) begin
            rf_we    = 1'b1;
            rf_waddr = st_q.x_idx;
            rf_wdata = cp_wdata;
        end else begin
            rf_we    = (cls == C_STAMP);
            rf_waddr = idx_cnt;
            rf_wdata = st_q.cnt;
        end

        arm[0] = (cls == C_FIQ_ARM);
        arm[1] = (cls == C_IRQ_ARM);
        rel[0] = (cls == C_FIQ_REL);
        rel[1] = (cls == C_IRQ_REL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        cpv_line_timer #(
            .CNT_W (DATA_W)
        ) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_i    (arm[g]),
            .count_i  (span),
            .rel_i    (rel[g]),
            .line_n_o (line_n[g])
        );
    end

    assign cycle_q  = st_q.cnt;
    assign cp_claim = claim;
    assign cp_rdata = xfer_word;
    assign cp_nfiq  = line_n[0];
    assign cp_nirq  = line_n[1];

endmodule

// File: rtl/cpv_checker.sv
module cpv_checker #(
    parameter int unsigned DATA_W = 32,
    parameter logic [3:0]  CP_A   = 4'd4,
    parameter logic [3:0]  CP_B   = 4'd5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cp_first,
    input logic [3:0]        cp_num,
    input logic [2:0]        cp_kind,
    input logic [31:0]       cp_instr,
    input logic              cp_poll,
    input logic              cp_data,
    input logic              cp_claim,
    input logic              cp_busy,
    input logic              cp_last,
    input logic              cp_nfiq,
    input logic              cp_nirq,
    input logic [DATA_W-1:0] cnt_i
);

    logic rel_fiq;
    logic rel_irq;

    assign rel_fiq = cp_claim && (cp_kind == 3'd0) && (cp_num == CP_B) && (cp_instr[23:20] == 4'd3);
    assign rel_irq = cp_claim && (cp_kind == 3'd0) && (cp_num == CP_B) && (cp_instr[23:20] == 4'd4);

    p_claim_num_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cp_claim |-> (cp_first && ((cp_num == CP_A) || (cp_num == CP_B))));

    p_last_in_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cp_last |-> cp_data);

    p_mem_primary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_claim && ((cp_kind == 3'd3) || (cp_kind == 3'd4))) |-> (cp_num == CP_A));

    p_busy_context_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cp_busy |-> (cp_first || cp_poll));

    p_fiq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_nfiq && !rel_fiq) |=> !cp_nfiq);

    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_nirq && !rel_irq) |=> !cp_nirq);

    p_fiq_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_fiq |=> cp_nfiq);

    p_irq_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_irq |=> cp_nirq);

    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cnt_i == $past(cnt_i) + DATA_W'(1)));

endmodule

bind cpval_engine cpv_checker #(
    .DATA_W (DATA_W),
    .CP_A   (CP_A),
    .CP_B   (CP_B)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cp_first (cp_first),
    .cp_num   (cp_num),
    .cp_kind  (cp_kind),
    .cp_instr (cp_instr),
    .cp_poll  (cp_poll),
    .cp_data  (cp_data),
    .cp_claim (cp_claim),
    .cp_busy  (cp_busy),
    .cp_last  (cp_last),
    .cp_nfiq  (cp_nfiq),
    .cp_nirq  (cp_nirq),
    .cnt_i    (cycle_q)
);

// File: tb/tb_cpval_engine.sv
module tb_cpval_engine;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [2:0]  kind;
        logic [3:0]  num;
        logic [3:0]  idx;
        logic [31:0] data;
        logic        claim;
    } row_t;

    localparam int NROW = 14;
    localparam row_t ROWS [NROW] = '{
        '{3'd1, 4'd4,  4'd1,  32'hA5A5_0001, 1'b1},
        '{3'd1, 4'd5,  4'd2,  32'h1234_5678, 1'b1},
        '{3'd1, 4'd6,  4'd1,  32'hDEAD_BEEF, 1'b0},
        '{3'd1, 4'd3,  4'd2,  32'hFFFF_FFFF, 1'b0},
        '{3'd3, 4'd5,  4'd1,  32'h0BAD_F00D, 1'b0},
        '{3'd4, 4'd5,  4'd2,  32'h0000_0000, 1'b0},
        '{3'd2, 4'd5,  4'd1,  32'hA5A5_0001, 1'b1},
        '{3'd2, 4'd4,  4'd2,  32'h1234_5678, 1'b1},
        '{3'd1, 4'd5,  4'd15, 32'hCAFE_0003, 1'b1},
        '{3'd2, 4'd4,  4'd15, 32'hCAFE_0003, 1'b1},
        '{3'd4, 4'd4,  4'd2,  32'h1234_5678, 1'b1},
        '{3'd3, 4'd4,  4'd12, 32'h00C0_FFEE, 1'b1},
        '{3'd2, 4'd5,  4'd12, 32'h00C0_FFEE, 1'b1},
        '{3'd2, 4'd15, 4'd12, 32'h0000_0000, 1'b0}
    };

    logic        clk;
    logic        rst_n;
    logic        cp_first;
    logic [3:0]  cp_num;
    logic [2:0]  cp_kind;
    logic [31:0] cp_instr;
    logic        cp_poll;
    logic        cp_data;
    logic [31:0] cp_wdata;
    logic        cp_claim;
    logic        cp_busy;
    logic        cp_last;
    logic [31:0] cp_rdata;
    logic        cp_nfiq;
    logic        cp_nirq;

    int checks;
    int errors;
    logic        s_claim;
    logic        s_busy;
    logic        s_last;
    logic [31:0] s_rdata;

    cpval_engine dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cp_first (cp_first),
        .cp_num   (cp_num),
        .cp_kind  (cp_kind),
        .cp_instr (cp_instr),
        .cp_poll  (cp_poll),
        .cp_data  (cp_data),
        .cp_wdata (cp_wdata),
        .cp_claim (cp_claim),
        .cp_busy  (cp_busy),
        .cp_last  (cp_last),
        .cp_rdata (cp_rdata),
        .cp_nfiq  (cp_nfiq),
        .cp_nirq  (cp_nirq)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive at a falling edge, sample combinational answers, wait for the next falling edge
    task automatic step(input logic f, input logic [3:0] n, input logic [2:0] k,
                        input logic [31:0] ins, input logic p, input logic d, input logic [31:0] w);
        cp_first = f; cp_num = n; cp_kind = k; cp_instr = ins;
        cp_poll = p; cp_data = d; cp_wdata = w;
        #1;
        s_claim = cp_claim; s_busy = cp_busy; s_last = cp_last; s_rdata = cp_rdata;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'd0, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic mcr(input logic [3:0] n, input logic [3:0] idx, input logic [31:0] v);
        step(1'b1, n, 3'd1, {12'h0, idx, 16'h0}, 1'b0, 1'b0, 32'h0);
        step(1'b0, 4'd0, 3'd0, 32'h0, 1'b0, 1'b1, v);
    endtask

    task automatic mrc(input logic [3:0] idx, output logic [31:0] v);
        step(1'b1, 4'd4, 3'd2, {12'h0, idx, 16'h0}, 1'b0, 1'b0, 32'h0);
        step(1'b0, 4'd0, 3'd0, 32'h0, 1'b0, 1'b1, 32'h0);
        v = s_rdata;
    endtask

    task automatic cdp(input logic [3:0] n, input logic [3:0] op, input logic [3:0] sel);
        step(1'b1, n, 3'd0, {8'h0, op, 16'h0, sel}, 1'b0, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] t0;
        checks = 0; errors = 0;
        rst_n = 1'b0;
        cp_first = 0; cp_num = 0; cp_kind = 0; cp_instr = 0;
        cp_poll = 0; cp_data = 0; cp_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        idle(1);
        chk("R10 nfiq", {31'h0, cp_nfiq}, 32'h1);
        chk("R10 nirq", {31'h0, cp_nirq}, 32'h1);
        chk("R10 busy", {31'h0, s_busy}, 32'h0);
        chk("R10 claim", {31'h0, s_claim}, 32'h0);
        chk("R10 last", {31'h0, s_last}, 32'h0);
        mrc(4'd11, v);
        chk("R10 reg11", v, 32'h0);

        // R1 R2 R3 R9: table of moves and transfers
        for (int r = 0; r < NROW; r++) begin
            step(1'b1, ROWS[r].num, ROWS[r].kind, {8'h0, ROWS[r].idx, ROWS[r].idx, 12'h0},
                 1'b0, 1'b0, 32'h0);
            chk($sformatf("R1 claim row %0d", r), {31'h0, s_claim}, {31'h0, ROWS[r].claim});
            if (ROWS[r].claim) begin
                step(1'b0, 4'd0, 3'd0, 32'h0, 1'b0, 1'b1,
                     (ROWS[r].kind == 3'd1 || ROWS[r].kind == 3'd3) ? ROWS[r].data : 32'h0);
                chk($sformatf("R2 last row %0d", r), {31'h0, s_last}, 32'h1);
                if (ROWS[r].kind == 3'd2 || ROWS[r].kind == 3'd4)
                    chk($sformatf("R2 R3 R9 rdata row %0d", r), s_rdata, ROWS[r].data);
            end
        end

        // R3: two-word load then two-word store on register 6
        step(1'b1, 4'd4, 3'd3, 32'h0040_6000, 1'b0, 1'b0, 32'h0);
        chk("R3 long load claim", {31'h0, s_claim}, 32'h1);
        step(1'b0, 4'd0, 3'd0, 32'h0, 1'b0, 1'b1, 32'h0000_0111);
        chk("R3 long load beat1 last", {31'h0, s_last}, 32'h0);
        step(1'b0, 4'd0, 3'd0, 32'h0, 1'b0, 1'b1, 32'h0000_0222);
        chk("R3 long load beat2 last", {31'h0, s_last}, 32'h1);
        mrc(4'd6, v);
        chk("R3 long load result", v, 32'h0000_0222);
        step(1'b1, 4'd4, 3'd4, 32'h0040_6000, 1'b0, 1'b0, 32'h0);
        step(1'b0, 4'd0, 3'd0, 32'h0, 1'b0, 1'b1, 32'h0);
        chk("R3 long store beat1 data", s_rdata, 32'h0000_0222);
        chk("R3 long store beat1 last", {31'h0, s_last}, 32'h0);
        step(1'b0, 4'd0, 3'd0, 32'h0, 1'b0, 1'b1, 32'h0);
        chk("R3 long store beat2 last", {31'h0, s_last}, 32'h1);

        // R4: stall of 4 cycles on CP 4
        mcr(4'd4, 4'd9, 32'd4);
        cdp(4'd4, 4'd0, 4'd9);
        chk("R4 stall first busy", {31'h0, s_busy}, 32'h1);
        for (int k = 1; k <= 4; k++) begin
            step(1'b0, 4'd4, 3'd0, 32'h0, 1'b1, 1'b0, 32'h0);
            chk($sformatf("R4 stall poll %0d", k), {31'h0, s_busy}, (k < 4) ? 32'h1 : 32'h0);
        end
        // R4: zero and one cycle stalls on CP 5
        mcr(4'd5, 4'd10, 32'd0);
        cdp(4'd5, 4'd0, 4'd10);
        chk("R4 zero stall claim", {31'h0, s_claim}, 32'h1);
        chk("R4 zero stall busy", {31'h0, s_busy}, 32'h0);
        mcr(4'd5, 4'd10, 32'd1);
        cdp(4'd5, 4'd0, 4'd10);
        chk("R4 one stall first", {31'h0, s_busy}, 32'h1);
        step(1'b0, 4'd5, 3'd0, 32'h0, 1'b1, 1'b0, 32'h0);
        chk("R4 one stall poll", {31'h0, s_busy}, 32'h0);

        // R5: FIQ after 3 edges
        mcr(4'd5, 4'd3, 32'd3);
        cdp(4'd5, 4'd1, 4'd3);
        chk("R5 fiq after 1 edge", {31'h0, cp_nfiq}, 32'h1);
        idle(1);
        chk("R5 fiq after 2 edges", {31'h0, cp_nfiq}, 32'h1);
        idle(1);
        chk("R5 fiq after 3 edges", {31'h0, cp_nfiq}, 32'h0);
        idle(3);
        chk("R5 fiq held", {31'h0, cp_nfiq}, 32'h0);
        chk("R6 irq independent", {31'h0, cp_nirq}, 32'h1);
        cdp(4'd5, 4'd3, 4'd0);
        chk("R7 fiq released", {31'h0, cp_nfiq}, 32'h1);

        // R6: IRQ with zero count is immediate
        mcr(4'd5, 4'd4, 32'd0);
        cdp(4'd5, 4'd2, 4'd4);
        chk("R6 irq immediate", {31'h0, cp_nirq}, 32'h0);
        chk("R6 fiq untouched", {31'h0, cp_nfiq}, 32'h1);
        cdp(4'd5, 4'd4, 4'd0);
        chk("R7 irq released", {31'h0, cp_nirq}, 32'h1);

        // R7: release cancels a pending countdown
        cdp(4'd5, 4'd1, 4'd3);
        cdp(4'd5, 4'd3, 4'd0);
        idle(5);
        chk("R7 cancel pending fiq", {31'h0, cp_nfiq}, 32'h1);

        // R11: restart extends the countdown
        mcr(4'd5, 4'd5, 32'd4);
        cdp(4'd5, 4'd1, 4'd5);
        idle(1);
        cdp(4'd5, 4'd1, 4'd5);
        idle(1);
        chk("R11 restart not yet", {31'h0, cp_nfiq}, 32'h1);
        idle(1);
        chk("R11 restart not yet 2", {31'h0, cp_nfiq}, 32'h1);
        idle(1);
        chk("R11 restart fires", {31'h0, cp_nfiq}, 32'h0);
        cdp(4'd5, 4'd3, 4'd0);

        // R9: rejected operations have no effect
        cdp(4'd4, 4'd1, 4'd3);
        chk("R9 op1 on cp4 claim", {31'h0, s_claim}, 32'h0);
        cdp(4'd4, 4'd2, 4'd4);
        chk("R9 op2 on cp4 claim", {31'h0, s_claim}, 32'h0);
        cdp(4'd5, 4'd7, 4'd0);
        chk("R9 op7 on cp5 claim", {31'h0, s_claim}, 32'h0);
        cdp(4'd4, 4'd5, 4'd13);
        chk("R9 stamp on cp4 claim", {31'h0, s_claim}, 32'h0);
        idle(5);
        chk("R9 nfiq unchanged", {31'h0, cp_nfiq}, 32'h1);
        chk("R9 nirq unchanged", {31'h0, cp_nirq}, 32'h1);
        mrc(4'd13, v);
        chk("R9 reg13 unchanged", v, 32'h0);

        // R8: two stamps 11 cycles apart
        cdp(4'd5, 4'd5, 4'd7);
        chk("R8 stamp claim", {31'h0, s_claim}, 32'h1);
        idle(10);
        cdp(4'd5, 4'd5, 4'd8);
        mrc(4'd7, t0);
        mrc(4'd8, v);
        chk("R8 stamp distance", v - t0, 32'd11);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule